// File: doc/BRIEF.md
# Nibble-Symbol ECC Codec

This block guards a 64-bit memory word with a 16-bit check field built from 4-bit symbols. The stored word is 80 bits wide: twenty symbols of 4 bits each, with each symbol going to its own memory device. When a whole device fails, only one symbol is damaged. The decoder can repair such a failure completely, whatever the pattern of bad bits inside that symbol. Damage that reaches two different symbols is reported as not repairable.

The write path takes 64 data bits together with the byte parity that arrived with them. It throws that parity away and computes four check symbols over GF(16), using the primitive polynomial x^4+x+1. The read path works on an 80-bit word in three steps:

- It recomputes the check symbols from the data part and XORs them with the stored ones to form a 4-symbol syndrome.
- It searches every column of the parity-check matrix, times every nonzero symbol value, for a match with that syndrome.
- It returns the data (repaired when a match is found), fresh even byte parity, and a classification of the word.

The classification takes one of three values: clean (zero syndrome), fixed (one match) or fatal (nonzero syndrome with no match). Each path has one register stage and a valid strobe.

Top module: `sym_ecc_codec`

## Requirements
- R1: Codeword layout: symbol j occupies code bits [4j+3:4j]. Symbols 0 to 15 are the data nibbles, unchanged (data bits [4j+3:4j]), and symbols 16 to 19 are check symbols 0 to 3. `enc_valid_o` and `enc_code_o` appear on the clock edge after `enc_valid_i` is sampled high.
- R2: GF(16) uses x^4 = x+1, with a symbol's bit i being the coefficient of x^i. Check symbol k equals the XOR over j of d_j times h_j[k]. For data symbol j, let z = j*j + 2*j + 6. The column is then h_j = (z, z+3, j+z+1, j+z+3), with row 0 first. The column of check symbol k is the unit vector with 1 in row k.
- R3: `enc_par_i` has no effect on `enc_code_o`.
- R4: A word with zero syndrome returns its data unchanged, with `dec_corrected_o`=0, `dec_uncorr_o`=0 and `dec_sym_o`=0.
- R5: Any nonzero error value (1 to 15) confined to data symbol p returns the original data, with `dec_corrected_o`=1, `dec_uncorr_o`=0 and `dec_sym_o`=p.
- R6: Any nonzero error value confined to check symbol p (16 to 19) returns the data unchanged, with `dec_corrected_o`=1 and `dec_sym_o`=p.
- R7: Nonzero errors in two distinct symbols give `dec_uncorr_o`=1, `dec_corrected_o`=0, `dec_sym_o`=0, and the received data bits passed through unmodified.
- R8: `dec_par_o[b]` equals the XOR of `dec_data_o[8b+7:8b]` (even parity over each byte).
- R9: `dec_valid_o` follows `dec_valid_i` by one clock. When `dec_valid_i` is low, the data, parity, flag and index outputs keep their previous values.
- R10: While `rst_n` is low, both valid outputs and both decoder flags are 0.
- R11: `dec_corrected_o` and `dec_uncorr_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Write-path word present |
| enc_data_i | input | 64 | Data to protect |
| enc_par_i | input | 8 | Incoming byte parity, discarded |
| enc_valid_o | output | 1 | Codeword valid |
| enc_code_o | output | 80 | Twenty-symbol codeword |
| dec_valid_i | input | 1 | Read-path word present |
| dec_code_i | input | 80 | Codeword read from the devices |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 64 | Data after repair |
| dec_par_o | output | 8 | Regenerated even byte parity |
| dec_corrected_o | output | 1 | One symbol was repaired |
| dec_uncorr_o | output | 1 | Damage beyond one symbol |
| dec_sym_o | output | 5 | Index of the repaired symbol |

## Verification
The bench injects every nonzero error value into every one of the twenty positions. This catches a parity-check column that is wrong at only one position, and a search that skips some error values: either fault shows up as a word flagged fatal, or as a repair at the wrong nibble. Errors in the check symbols are exercised separately, because a design that let such a hit touch the data path would corrupt good data. Random pairs of damaged symbols show whether some double error aliases onto a single-symbol syndrome and gets miscorrected silently. Further cases confirm that the incoming parity is ignored and that the outputs hold while the read strobe is low.

// File: rtl/sym_ecc_pkg.sv
package sym_ecc_pkg;
    localparam int SYM_W     = 4;
    localparam int DATA_W    = 64;
    localparam int CHK_SYMS  = 4;
    localparam int DATA_SYMS = DATA_W / SYM_W;
    localparam int ALL_SYMS  = DATA_SYMS + CHK_SYMS;
    localparam int CODE_W    = ALL_SYMS * SYM_W;
    localparam int IDX_W     = $clog2(ALL_SYMS);
    localparam int BYTES     = DATA_W / 8;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [CHK_SYMS-1:0][SYM_W-1:0] col_t;
    typedef enum logic [1:0] {RES_CLEAN, RES_FIXED, RES_FATAL} res_kind_t;

    // x^4 folds back to x+1
    localparam sym_t FB_TAPS  = 4'b0011;
    // constants of the column formula: second coordinate fixed at x,
    // its quadric term and its cross term folded in
    localparam sym_t Y_SEL    = 4'h2;
    localparam sym_t Q_CONST  = 4'h6;
    localparam sym_t CY_CONST = 4'h3;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ((sh << 1) ^ FB_TAPS) : (sh << 1);
        end
        return acc;
    endfunction

    // parity-check column of symbol position p
    function automatic col_t h_col(input int p);
        col_t c;
        sym_t x;
        sym_t z;
        c = '0;
        if (p < DATA_SYMS) begin
            x    = sym_t'(p);
            z    = gf_mul(x, x) ^ gf_mul(Y_SEL, x) ^ Q_CONST;
            c[0] = z;
            c[1] = z ^ CY_CONST;
            c[2] = x ^ z ^ 4'h1;
            c[3] = x ^ z ^ CY_CONST;
        end else begin
            c[p - DATA_SYMS] = 4'h1;
        end
        return c;
    endfunction

    function automatic col_t scale_col(input sym_t e, input col_t c);
        col_t r;
        for (int k = 0; k < CHK_SYMS; k++) r[k] = gf_mul(e, c[k]);
        return r;
    endfunction
endpackage

// File: rtl/sym_ecc_enc.sv
module sym_ecc_enc
    import sym_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output col_t              chk_o
);
    col_t term [DATA_SYMS];

    for (genvar j = 0; j < DATA_SYMS; j++) begin : g_term
        localparam col_t HJ = h_col(j);
        assign term[j] = scale_col(data_i[j*SYM_W +: SYM_W], HJ);
    end

    always_comb begin
        chk_o = '0;
        for (int j = 0; j < DATA_SYMS; j++) chk_o = chk_o ^ term[j];
    end
endmodule

// File: rtl/sym_ecc_syn.sv
module sym_ecc_syn
    import sym_ecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output col_t              syn_o
);
    col_t recomputed;

    sym_ecc_enc u_enc (
        .data_i (code_i[DATA_W-1:0]),
        .chk_o  (recomputed)
    );

    assign syn_o = recomputed ^ col_t'(code_i[CODE_W-1:DATA_W]);
endmodule

// File: rtl/sym_ecc_loc.sv
module sym_ecc_loc
    import sym_ecc_pkg::*;
(
    input  col_t             syn_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] pos_o,
    output sym_t             val_o
);
    logic [ALL_SYMS-1:0] hit_v;
    sym_t                val_v [ALL_SYMS];

    for (genvar p = 0; p < ALL_SYMS; p++) begin : g_pos
        localparam col_t COL = h_col(p);
        logic l_hit;
        sym_t l_val;
        always_comb begin
            l_hit = 1'b0;
            l_val = '0;
            for (int e = 1; e < (1 << SYM_W); e++) begin
                if (!l_hit && scale_col(sym_t'(e), COL) == syn_i) begin
                    l_hit = 1'b1;
                    l_val = sym_t'(e);
                end
            end
        end
        assign hit_v[p] = l_hit;
        assign val_v[p] = l_val;
    end

    // lowest position wins; a valid code has at most one hit
    always_comb begin
        hit_o = 1'b0;
        pos_o = '0;
        val_o = '0;
        for (int p = ALL_SYMS - 1; p >= 0; p--) begin
            if (hit_v[p]) begin
                hit_o = 1'b1;
                pos_o = IDX_W'(p);
                val_o = val_v[p];
            end
        end
    end
endmodule

// File: rtl/sym_ecc_codec.sv
module sym_ecc_codec
    import sym_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    input  logic [BYTES-1:0]  enc_par_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [BYTES-1:0]  dec_par_o,
    output logic              dec_corrected_o,
    output logic              dec_uncorr_o,
    output logic [IDX_W-1:0]  dec_sym_o
);
    // incoming parity is replaced by the check symbols
    logic sink_unused;
    assign sink_unused = ^enc_par_i;

    // write path
    col_t enc_chk;

    sym_ecc_enc u_enc (
        .data_i (enc_data_i),
        .chk_o  (enc_chk)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_valid_o <= 1'b0;
            enc_code_o  <= '0;
        end else begin
            enc_valid_o <= enc_valid_i;
            if (enc_valid_i) enc_code_o <= {enc_chk, enc_data_i};
        end
    end

    // read path
    col_t             syn;
    logic             loc_hit;
    logic [IDX_W-1:0] loc_pos;
    sym_t             loc_val;
    res_kind_t        kind;
    logic [DATA_W-1:0] fix_data;
    logic [BYTES-1:0] fix_par;
    logic             nxt_corr;
    logic             nxt_unc;
    logic [IDX_W-1:0] nxt_sym;

    sym_ecc_syn u_syn (
        .code_i (dec_code_i),
        .syn_o  (syn)
    );

    sym_ecc_loc u_loc (
        .syn_i  (syn),
        .hit_o  (loc_hit),
        .pos_o  (loc_pos),
        .val_o  (loc_val)
    );

    always_comb begin
        if (syn == '0)    kind = RES_CLEAN;
        else if (loc_hit) kind = RES_FIXED;
        else              kind = RES_FATAL;
    end

    always_comb begin
        fix_data = dec_code_i[DATA_W-1:0];
        if (kind == RES_FIXED && int'(loc_pos) < DATA_SYMS)
            fix_data[int'(loc_pos)*SYM_W +: SYM_W] =
                fix_data[int'(loc_pos)*SYM_W +: SYM_W] ^ loc_val;
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_par
        assign fix_par[b] = ^fix_data[b*8 +: 8];
    end

    always_comb begin
        unique case (kind)
            RES_CLEAN: begin
                nxt_corr = 1'b0;
                nxt_unc  = 1'b0;
                nxt_sym  = '0;
            end
            RES_FIXED: begin
                nxt_corr = 1'b1;
                nxt_unc  = 1'b0;
                nxt_sym  = loc_pos;
            end
            default: begin
                nxt_corr = 1'b0;
                nxt_unc  = 1'b1;
                nxt_sym  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid_o     <= 1'b0;
            dec_data_o      <= '0;
            dec_par_o       <= '0;
            dec_corrected_o <= 1'b0;
            dec_uncorr_o    <= 1'b0;
            dec_sym_o       <= '0;
        end else begin
            dec_valid_o <= dec_valid_i;
            if (dec_valid_i) begin
                dec_data_o      <= fix_data;
                dec_par_o       <= fix_par;
                dec_corrected_o <= nxt_corr;
                dec_uncorr_o    <= nxt_unc;
                dec_sym_o       <= nxt_sym;
            end
        end
    end
endmodule

// File: rtl/sym_ecc_codec_chk.sv
module sym_ecc_codec_chk
    import sym_ecc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid_i,
    input logic [DATA_W-1:0] enc_data_i,
    input logic              enc_valid_o,
    input logic [DATA_W-1:0] enc_low_i,
    input logic              dec_valid_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [BYTES-1:0]  dec_par_o,
    input logic              dec_corrected_o,
    input logic              dec_uncorr_o,
    input logic [IDX_W-1:0]  dec_sym_o
);
    p_enc_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);

    p_enc_data_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_low_i == $past(enc_data_i));

    p_dec_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    p_dec_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> !dec_valid_o);

    p_dec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> $stable(dec_data_o) && $stable(dec_sym_o));

    p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_corrected_o && dec_uncorr_o));

    p_fix_index_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_corrected_o |-> int'(dec_sym_o) < ALL_SYMS);

    p_fatal_index_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_uncorr_o |-> dec_sym_o == '0);

    for (genvar b = 0; b < BYTES; b++) begin : g_par_chk
        p_even_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid_o |-> (^{dec_data_o[b*8 +: 8], dec_par_o[b]}) == 1'b0);
    end

    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r10: assert (!enc_valid_o && !dec_valid_o
                                       && !dec_corrected_o && !dec_uncorr_o);
        end
    end
endmodule

bind sym_ecc_codec sym_ecc_codec_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enc_valid_i     (enc_valid_i),
    .enc_data_i      (enc_data_i),
    .enc_valid_o     (enc_valid_o),
    .enc_low_i       (enc_code_o[63:0]),
    .dec_valid_i     (dec_valid_i),
    .dec_valid_o     (dec_valid_o),
    .dec_data_o      (dec_data_o),
    .dec_par_o       (dec_par_o),
    .dec_corrected_o (dec_corrected_o),
    .dec_uncorr_o    (dec_uncorr_o),
    .dec_sym_o       (dec_sym_o)
);

// File: tb/tb_sym_ecc_codec.sv
module tb_sym_ecc_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [63:0] enc_data_i = '0;
    logic [7:0]  enc_par_i = '0;
    logic        enc_valid_o;
    logic [79:0] enc_code_o;
    logic        dec_valid_i = 1'b0;
    logic [79:0] dec_code_i = '0;
    logic        dec_valid_o;
    logic [63:0] dec_data_o;
    logic [7:0]  dec_par_o;
    logic        dec_corrected_o;
    logic        dec_uncorr_o;
    logic [4:0]  dec_sym_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    sym_ecc_codec dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .enc_valid_i     (enc_valid_i),
        .enc_data_i      (enc_data_i),
        .enc_par_i       (enc_par_i),
        .enc_valid_o     (enc_valid_o),
        .enc_code_o      (enc_code_o),
        .dec_valid_i     (dec_valid_i),
        .dec_code_i      (dec_code_i),
        .dec_valid_o     (dec_valid_o),
        .dec_data_o      (dec_data_o),
        .dec_par_o       (dec_par_o),
        .dec_corrected_o (dec_corrected_o),
        .dec_uncorr_o    (dec_uncorr_o),
        .dec_sym_o       (dec_sym_o)
    );

    // reference arithmetic: carry-less product, then long division by x^4+x+1
    function automatic logic [3:0] ref_mul(input logic [3:0] a, input logic [3:0] b);
        logic [6:0] prod;
        prod = '0;
        for (int i = 0; i < 4; i++)
            if (b[i]) prod = prod ^ (7'(a) << i);
        for (int d = 6; d >= 4; d--)
            if (prod[d]) prod = prod ^ (7'b0010011 << (d - 4));
        return prod[3:0];
    endfunction

    function automatic logic [15:0] ref_col(input int p);
        logic [3:0] x, z;
        logic [15:0] c;
        if (p >= 16) begin
            c = 16'h1 << (4 * (p - 16));
        end else begin
            x = 4'(p);
            z = ref_mul(x, x) ^ ref_mul(4'h2, x) ^ 4'h6;
            c = {x ^ z ^ 4'h3, x ^ z ^ 4'h1, z ^ 4'h3, z};
        end
        return c;
    endfunction

    function automatic logic [79:0] ref_encode(input logic [63:0] d);
        logic [15:0] chk;
        logic [15:0] col;
        chk = '0;
        for (int j = 0; j < 16; j++) begin
            col = ref_col(j);
            for (int k = 0; k < 4; k++)
                chk[4*k +: 4] = chk[4*k +: 4] ^ ref_mul(d[4*j +: 4], col[4*k +: 4]);
        end
        return {chk, d};
    endfunction

    function automatic logic [7:0] ref_par(input logic [63:0] d);
        logic [7:0] p;
        for (int b = 0; b < 8; b++) p[b] = ^d[8*b +: 8];
        return p;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // apply inputs at a falling edge, results are visible at the next falling edge
    task automatic step(input logic ev, input logic [63:0] ed, input logic [7:0] ep,
                        input logic dv, input logic [79:0] dc);
        enc_valid_i = ev;
        enc_data_i  = ed;
        enc_par_i   = ep;
        dec_valid_i = dv;
        dec_code_i  = dc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_dec(input string req, input logic [63:0] d,
                              input logic corr, input logic unc, input logic [4:0] sym);
        check(req, "dec_valid", 80'(dec_valid_o), 80'(1'b1));
        check(req, "dec_data", 80'(dec_data_o), 80'(d));
        check("R8", "dec_par", 80'(dec_par_o), 80'(ref_par(d)));
        check(req, "corrected", 80'(dec_corrected_o), 80'(corr));
        check(req, "uncorr", 80'(dec_uncorr_o), 80'(unc));
        check(req, "sym", 80'(dec_sym_o), 80'(sym));
        check("R11", "flag_overlap", 80'(dec_corrected_o & dec_uncorr_o), 80'(1'b0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        logic [79:0] cw;
        logic [79:0] first;

        // R10: reset state, with inputs strobed during reset
        @(negedge clk);
        enc_valid_i = 1'b1;
        dec_valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R10", "enc_valid", 80'(enc_valid_o), 80'(1'b0));
        check("R10", "dec_valid", 80'(dec_valid_o), 80'(1'b0));
        check("R10", "flags", 80'({dec_corrected_o, dec_uncorr_o}), 80'(2'b00));
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: encoder over fixed and random patterns
        for (int i = 0; i < 24; i++) begin
            if (i == 0)      d = '0;
            else if (i == 1) d = '1;
            else if (i == 2) d = 64'h0123456789ABCDEF;
            else             d = {$urandom, $urandom};
            step(1'b1, d, 8'($urandom), 1'b0, '0);
            check("R1", "enc_valid", 80'(enc_valid_o), 80'(1'b1));
            check("R2", "enc_code", enc_code_o, ref_encode(d));
        end

        // R3: parity input flipped, codeword unchanged
        d = 64'hFEDCBA9876543210;
        step(1'b1, d, 8'h00, 1'b0, '0);
        first = enc_code_o;
        step(1'b1, d, 8'hFF, 1'b0, '0);
        check("R3", "parity_ignored", enc_code_o, first);
        step(1'b1, d, ~ref_par(d), 1'b0, '0);
        check("R3", "bad_parity_ignored", enc_code_o, ref_encode(d));

        // R4: clean words
        for (int i = 0; i < 16; i++) begin
            d = (i == 0) ? 64'h0 : {$urandom, $urandom};
            step(1'b0, '0, '0, 1'b1, ref_encode(d));
            expect_dec("R4", d, 1'b0, 1'b0, 5'd0);
        end

        // R5 R6: every nonzero value at every symbol position
        for (int p = 0; p < 20; p++) begin
            for (int e = 1; e < 16; e++) begin
                d  = {$urandom, $urandom};
                cw = ref_encode(d) ^ (80'(e) << (4 * p));
                step(1'b0, '0, '0, 1'b1, cw);
                if (p < 16) expect_dec("R5", d, 1'b1, 1'b0, 5'(p));
                else        expect_dec("R6", d, 1'b1, 1'b0, 5'(p));
            end
        end

        // R7: damage in two distinct symbols
        for (int i = 0; i < 400; i++) begin
            int p1, p2;
            p1 = $urandom_range(0, 19);
            do p2 = $urandom_range(0, 19); while (p2 == p1);
            d  = {$urandom, $urandom};
            cw = ref_encode(d) ^ (80'($urandom_range(1, 15)) << (4 * p1))
                               ^ (80'($urandom_range(1, 15)) << (4 * p2));
            step(1'b0, '0, '0, 1'b1, cw);
            expect_dec("R7", cw[63:0], 1'b0, 1'b1, 5'd0);
        end

        // R9: a repaired word, then an idle cycle with a different word on the bus
        d  = 64'hA5A5_5A5A_0F0F_F0F0;
        cw = ref_encode(d) ^ (80'hC << 12);
        step(1'b0, '0, '0, 1'b1, cw);
        expect_dec("R5", d, 1'b1, 1'b0, 5'd3);
        step(1'b0, '0, '0, 1'b0, ~cw);
        check("R9", "idle_valid", 80'(dec_valid_o), 80'(1'b0));
        check("R9", "hold_data", 80'(dec_data_o), 80'(d));
        check("R9", "hold_flags", 80'({dec_corrected_o, dec_uncorr_o, dec_sym_o}),
              80'({1'b1, 1'b0, 5'd3}));
        step(1'b0, '0, '0, 1'b0, '0);
        check("R1", "enc_idle", 80'(enc_valid_o), 80'(1'b0));

        finish_run();
    end
endmodule